// File: doc/BRIEF.md
# Beacon Power-Save Sequencer

This block runs the infrastructure power-save loop of a wireless station's network subsystem. With no traffic, it keeps the subsystem in a retained low-power sleep state. A wake timer brings it into a listen mode a programmable margin before each expected beacon. Listen mode receives beacon frames only. If the beacon reports no buffered traffic, the block goes back to sleep and the loop repeats. If the beacon reports pending traffic, the block goes fully active.

The active part has two levels. The upper level handles IP packets as well as MAC management frames. The lower level handles management frames only. With no IP activity for an idle period, the block steps down from the upper level to the lower one. With no management activity for a second idle period, it returns to sleep. A host transmit request forces the upper active level from any state except disabled. Clearing the enable input puts the block into a disabled mode, and no cycling takes place there.

When no beacon arrives within the listen window, the block records a missed beacon and goes back to sleep. All intervals are counted in clock cycles and are taken from inputs.

Top module: `beacon_ps_seq`

## Requirements
- R1: After reset, `mode_o` is 0 (disabled), `rx_en_o`, `mac_en_o` and `ip_en_o` are 0, and `miss_cnt_o` is 0.
- R2: When `enable_i` is low at a clock edge, the next mode is disabled (0) from any state. The block stays disabled while `enable_i` is low, whatever the other inputs do.
- R3: When `enable_i` is high in the disabled mode, the block enters sleep (mode 1). Sleep lasts `bcn_intv_i - prewake_i` cycles, with a minimum of 1 cycle, and is then followed by listen (mode 2).
- R4: The mode codes and the enables are as follows. Disabled (0) and sleep (1) drive all enables to 0. Listen (2) drives only `rx_en_o`. The management-only active level (3) drives `rx_en_o` and `mac_en_o`. The full active level (4) drives all three enables.
- R5: In listen, a beacon strobe with `bcn_pend_i`=0 returns the block to sleep on the next cycle. The next sleep period has the same length as before.
- R6: In listen, a beacon strobe with `bcn_pend_i`=1 moves the block to full active (4) on the next cycle.
- R7: When listen lasts `listen_to_i` cycles with no beacon, the block returns to sleep and `miss_cnt_o` increments. The count saturates at its maximum value.
- R8: The block leaves full active for the management-only level after `idle_lim_i` consecutive cycles with neither `ip_act_i` nor `host_req_i`. Either of those inputs restarts the count.
- R9: In the management-only level, `ip_act_i` returns the block to full active. Otherwise the block returns to sleep after `idle_lim_i` cycles without `mac_act_i`, and `mac_act_i` restarts the count.
- R10: `host_req_i` moves the block to full active on the next cycle from sleep, listen or the management-only level. It takes priority over a beacon in the same cycle. It has no effect in the disabled mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| enable_i | input | 1 | Low selects the disabled mode |
| bcn_intv_i | input | TMR_W | Beacon interval in cycles |
| prewake_i | input | TMR_W | Margin to wake before the beacon |
| listen_to_i | input | TMR_W | Listen window in cycles |
| idle_lim_i | input | TMR_W | Idle period for each active level |
| bcn_rx_i | input | 1 | Beacon received strobe |
| bcn_pend_i | input | 1 | Beacon reports buffered traffic |
| mac_act_i | input | 1 | Management frame activity |
| ip_act_i | input | 1 | IP packet activity |
| host_req_i | input | 1 | Host transmit request |
| mode_o | output | 3 | Current mode code |
| rx_en_o | output | 1 | Receiver enable |
| mac_en_o | output | 1 | Management layer enable |
| ip_en_o | output | 1 | IP layer enable |
| miss_cnt_o | output | MISS_W | Saturating count of missed beacons |

## Verification
On every cycle, the assertions check the single-step transitions. These are the forced entry to the disabled mode, the exit to sleep, the host wake, the outcome of a received beacon, and the fact that sleep never jumps directly to the management-only level. They also check that only listen can change the miss count, and that sleep keeps every enable low. Interval lengths cannot be checked from one transition: the sleep duration derived from the interval and margin, the listen timeout, the two idle step-downs with their restarts, and counter saturation. The bench scenarios check these by counting cycles.

// File: rtl/ps_pkg.sv
package ps_pkg;
  typedef enum logic [2:0] {
    MODE_OFF     = 3'd0,
    MODE_SLEEP   = 3'd1,
    MODE_LISTEN  = 3'd2,
    MODE_ACT_MAC = 3'd3,
    MODE_ACT_IP  = 3'd4
  } ps_mode_e;
endpackage

// File: rtl/ps_timer.sv
module ps_timer #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] val_i,
  output logic         exp_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (load_i)        cnt_q <= val_i;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  // expires in the cycle that completes the loaded count
  assign exp_o = (cnt_q <= W'(1));
endmodule

// File: rtl/ps_sat_cnt.sv
module ps_sat_cnt #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         inc_i,
  output logic [W-1:0] cnt_o
);
  localparam logic [W-1:0] MAX = '1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    cnt_o <= '0;
    else if (inc_i && cnt_o != MAX) cnt_o <= cnt_o + 1'b1;
  end
endmodule

// File: rtl/ps_fsm.sv
module ps_fsm
  import ps_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         enable_i,
  input  logic         host_req_i,
  input  logic         bcn_rx_i,
  input  logic         bcn_pend_i,
  input  logic         mac_act_i,
  input  logic         ip_act_i,
  input  logic         exp_i,
  input  logic [W-1:0] sleep_len_i,
  input  logic [W-1:0] listen_to_i,
  input  logic [W-1:0] idle_lim_i,
  output ps_mode_e     mode_o,
  output logic         load_o,
  output logic [W-1:0] load_val_o,
  output logic         miss_o
);
  ps_mode_e nxt;
  logic     reload;

  always_comb begin
    nxt    = mode_o;
    reload = 1'b0;
    miss_o = 1'b0;
    unique case (mode_o)
      MODE_OFF:    nxt = MODE_SLEEP;
      MODE_SLEEP: begin
        if (host_req_i) nxt = MODE_ACT_IP;
        else if (exp_i) nxt = MODE_LISTEN;
      end
      MODE_LISTEN: begin
        if (host_req_i)    nxt = MODE_ACT_IP;
        else if (bcn_rx_i) nxt = bcn_pend_i ? MODE_ACT_IP : MODE_SLEEP;
        else if (exp_i) begin
          nxt    = MODE_SLEEP;
          miss_o = 1'b1;
        end
      end
      MODE_ACT_IP: begin
        if (host_req_i || ip_act_i) reload = 1'b1;
        else if (exp_i)             nxt = MODE_ACT_MAC;
      end
      MODE_ACT_MAC: begin
        if (host_req_i || ip_act_i) nxt = MODE_ACT_IP;
        else if (mac_act_i)         reload = 1'b1;
        else if (exp_i)             nxt = MODE_SLEEP;
      end
      default: nxt = MODE_OFF;
    endcase
    if (!enable_i) begin
      nxt    = MODE_OFF;
      reload = 1'b0;
      miss_o = 1'b0;
    end
  end

  assign load_o = reload || (nxt != mode_o);

  always_comb begin
    unique case (nxt)
      MODE_SLEEP:                load_val_o = sleep_len_i;
      MODE_LISTEN:               load_val_o = listen_to_i;
      MODE_ACT_MAC, MODE_ACT_IP: load_val_o = idle_lim_i;
      default:                   load_val_o = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mode_o <= MODE_OFF;
    else         mode_o <= nxt;
  end
endmodule

// File: rtl/beacon_ps_seq.sv
module beacon_ps_seq
  import ps_pkg::*;
#(
  parameter int TMR_W  = 16,
  parameter int MISS_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              enable_i,
  input  logic [TMR_W-1:0]  bcn_intv_i,
  input  logic [TMR_W-1:0]  prewake_i,
  input  logic [TMR_W-1:0]  listen_to_i,
  input  logic [TMR_W-1:0]  idle_lim_i,
  input  logic              bcn_rx_i,
  input  logic              bcn_pend_i,
  input  logic              mac_act_i,
  input  logic              ip_act_i,
  input  logic              host_req_i,
  output logic [2:0]        mode_o,
  output logic              rx_en_o,
  output logic              mac_en_o,
  output logic              ip_en_o,
  output logic [MISS_W-1:0] miss_cnt_o
);
  ps_mode_e         mode;
  logic             exp, load, miss;
  logic [TMR_W-1:0] load_val, sleep_len;

  // margin at or above the interval gives the shortest sleep
  assign sleep_len = (prewake_i >= bcn_intv_i) ? '0 : bcn_intv_i - prewake_i;

  ps_fsm #(.W(TMR_W)) u_fsm (
    .clk_i, .rst_ni, .enable_i, .host_req_i, .bcn_rx_i, .bcn_pend_i,
    .mac_act_i, .ip_act_i,
    .exp_i       (exp),
    .sleep_len_i (sleep_len),
    .listen_to_i,
    .idle_lim_i,
    .mode_o      (mode),
    .load_o      (load),
    .load_val_o  (load_val),
    .miss_o      (miss)
  );

  ps_timer #(.W(TMR_W)) u_tmr (
    .clk_i, .rst_ni,
    .load_i (load),
    .val_i  (load_val),
    .exp_o  (exp)
  );

  ps_sat_cnt #(.W(MISS_W)) u_miss (
    .clk_i, .rst_ni,
    .inc_i (miss),
    .cnt_o (miss_cnt_o)
  );

  assign mode_o   = mode;
  assign rx_en_o  = (mode == MODE_LISTEN) || (mode == MODE_ACT_MAC) || (mode == MODE_ACT_IP);
  assign mac_en_o = (mode == MODE_ACT_MAC) || (mode == MODE_ACT_IP);
  assign ip_en_o  = (mode == MODE_ACT_IP);
endmodule

// File: rtl/beacon_ps_seq_chk.sv
module beacon_ps_seq_chk #(
  parameter int MISS_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              enable_i,
  input logic              host_req_i,
  input logic              bcn_rx_i,
  input logic              bcn_pend_i,
  input logic [2:0]        mode_o,
  input logic              rx_en_o,
  input logic              mac_en_o,
  input logic              ip_en_o,
  input logic [MISS_W-1:0] miss_cnt_o
);
  // R2
  off_on_disable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !enable_i |=> mode_o == 3'd0);

  // R3
  off_exit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    enable_i && mode_o == 3'd0 |=> mode_o == 3'd1);

  // R10
  host_wake_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    enable_i && host_req_i && mode_o != 3'd0 |=> mode_o == 3'd4);

  // R5
  bcn_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    enable_i && !host_req_i && mode_o == 3'd2 && bcn_rx_i && !bcn_pend_i |=> mode_o == 3'd1);

  // R6
  bcn_pend_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    enable_i && mode_o == 3'd2 && bcn_rx_i && bcn_pend_i |=> mode_o == 3'd4);

  // R4
  sleep_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_o == 3'd1 |-> !rx_en_o && !mac_en_o && !ip_en_o);

  // R9
  no_mac_from_sleep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_o == 3'd1 |=> mode_o != 3'd3);

  // R7
  miss_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    miss_cnt_o != $past(miss_cnt_o) |-> $past(mode_o) == 3'd2);
endmodule

bind beacon_ps_seq beacon_ps_seq_chk #(.MISS_W(MISS_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .enable_i   (enable_i),
  .host_req_i (host_req_i),
  .bcn_rx_i   (bcn_rx_i),
  .bcn_pend_i (bcn_pend_i),
  .mode_o     (mode_o),
  .rx_en_o    (rx_en_o),
  .mac_en_o   (mac_en_o),
  .ip_en_o    (ip_en_o),
  .miss_cnt_o (miss_cnt_o)
);

// File: tb/beacon_ps_seq_test.sv
module beacon_ps_seq_test;
  localparam int TMR_W  = 16;
  localparam int MISS_W = 8;
  localparam int INTV = 20, PRE = 5, LTO = 6, IDLE = 4;
  localparam int SLP = INTV - PRE;

  logic clk_i = 1'b0, rst_ni = 1'b0, enable_i = 1'b0;
  logic bcn_rx_i = 1'b0, bcn_pend_i = 1'b0, mac_act_i = 1'b0, ip_act_i = 1'b0, host_req_i = 1'b0;
  logic [TMR_W-1:0] bcn_intv_i = TMR_W'(INTV), prewake_i = TMR_W'(PRE);
  logic [TMR_W-1:0] listen_to_i = TMR_W'(LTO), idle_lim_i = TMR_W'(IDLE);
  logic [2:0] mode_o;
  logic rx_en_o, mac_en_o, ip_en_o;
  logic [MISS_W-1:0] miss_cnt_o;
  int checks = 0, errors = 0;
  bit done = 0;

  always #5 clk_i = ~clk_i;

  beacon_ps_seq #(.TMR_W(TMR_W), .MISS_W(MISS_W)) uut (.*);

  task automatic tick(input int n);
    repeat (n) begin @(posedge clk_i); #2; end
  endtask

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic chk_mode(input string req, input int m);
    chk(req, mode_o, m);
    chk(req, {rx_en_o, mac_en_o, ip_en_o},
        (m == 2) ? 3'b100 : (m == 3) ? 3'b110 : (m == 4) ? 3'b111 : 3'b000);
  endtask

  task automatic t_reset();
    #2;
    chk_mode("R1", 0);
    chk("R1", miss_cnt_o, 0);
    rst_ni = 1'b1;
    host_req_i = 1'b1;
    tick(2);
    chk_mode("R2", 0);  // disabled stays put; host ignored (R10)
    host_req_i = 1'b0;
  endtask

  task automatic t_cycle();
    enable_i = 1'b1;
    tick(1);
    chk_mode("R3", 1);
    tick(SLP - 1);
    chk_mode("R3", 1);
    tick(1);
    chk_mode("R3", 2);
    bcn_rx_i = 1'b1; bcn_pend_i = 1'b0;
    tick(1);
    bcn_rx_i = 1'b0;
    chk_mode("R5", 1);
    tick(SLP - 1);
    chk_mode("R5", 1);
    tick(1);
    chk_mode("R5", 2);
  endtask

  task automatic t_miss();
    tick(LTO - 1);
    chk_mode("R7", 2);
    chk("R7", miss_cnt_o, 0);
    tick(1);
    chk_mode("R7", 1);
    chk("R7", miss_cnt_o, 1);
    tick(SLP);
    chk_mode("R7", 2);
  endtask

  task automatic t_active();
    bcn_rx_i = 1'b1; bcn_pend_i = 1'b1;
    tick(1);
    bcn_rx_i = 1'b0; bcn_pend_i = 1'b0;
    chk_mode("R6", 4);
    tick(IDLE - 1);
    chk_mode("R8", 4);
    ip_act_i = 1'b1;
    tick(1);
    ip_act_i = 1'b0;
    tick(IDLE - 1);
    chk_mode("R8", 4);
    tick(1);
    chk_mode("R8", 3);
    ip_act_i = 1'b1;
    tick(1);
    ip_act_i = 1'b0;
    chk_mode("R9", 4);
    tick(IDLE);
    chk_mode("R8", 3);
    tick(2);
    mac_act_i = 1'b1;
    tick(1);
    mac_act_i = 1'b0;
    tick(IDLE - 1);
    chk_mode("R9", 3);
    tick(1);
    chk_mode("R9", 1);
  endtask

  task automatic t_host();
    host_req_i = 1'b1;
    tick(1);
    host_req_i = 1'b0;
    chk_mode("R10", 4);
    tick(2 * IDLE);
    chk_mode("R9", 1);
    tick(SLP);
    chk_mode("R3", 2);
    host_req_i = 1'b1; bcn_rx_i = 1'b1; bcn_pend_i = 1'b0;
    tick(1);
    host_req_i = 1'b0; bcn_rx_i = 1'b0;
    chk_mode("R10", 4);
    tick(IDLE);
    host_req_i = 1'b1;
    tick(1);
    host_req_i = 1'b0;
    chk_mode("R10", 4);
  endtask

  task automatic t_disable();
    enable_i = 1'b0;
    tick(1);
    chk_mode("R2", 0);
    host_req_i = 1'b1; bcn_rx_i = 1'b1; bcn_pend_i = 1'b1;
    tick(3);
    chk_mode("R2", 0);
    host_req_i = 1'b0; bcn_rx_i = 1'b0; bcn_pend_i = 1'b0;
    enable_i = 1'b1;
    tick(1);
    chk_mode("R3", 1);
    enable_i = 1'b0;
    tick(1);
    chk_mode("R2", 0);
    chk("R7", miss_cnt_o, 1);
  endtask

  task automatic t_saturate();
    enable_i = 1'b1;
    tick(300 * (SLP + LTO + 1));
    chk("R7", miss_cnt_o, 255);
  endtask

  initial begin
    t_reset();
    t_cycle();
    t_miss();
    t_active();
    t_host();
    t_disable();
    t_saturate();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule